// File: doc/BRIEF.md
# Handshaked Register Slave for a Mapper Control Plane

This block is the software-facing register file of a bit-stream mapper. It has an insert side and an extract side. A bus master reaches it over a small synchronous bus. The bus has a select line, a read/write line (high means read), a 4-bit byte address, an 8-bit write data bus, an 8-bit read data bus and a transfer acknowledge. Twelve registers hold the following:
- an enable for each side
- the sync status of each side
- two sticky interrupt flags per side, each with its own enable mask
- two overhead communication bits per side
- a pair of 5-bit FIFO fill marks

The acknowledge follows a four-phase handshake. It rises one cycle after the block sees select, stays high while select is held, and falls one cycle after select is removed. A master in another clock domain can therefore pace each transfer purely on levels. Outside an acknowledged read, the read data is forced to zero, so several slaves can share one read bus through an OR. Interrupt flags are set by event pulses from the datapath cores, cleared by reading them, and combined with their enables into one interrupt request.

Top module: `hs_reg_slave`

## Requirements
- R1: After synchronous reset, every register reads 0, and `ack`, `rdata`, `irq`, `ins_en`, `ext_en`, `ins_oh`, `hi_mark` and `lo_mark` are all 0.
- R2: `ack` goes high on the first clock edge at which `sel` is high, stays high while `sel` stays high, and goes low on the first edge at which `sel` is low.
- R3: `rdata` is 0 in every cycle in which `ack` is low. During an acknowledged read it holds the value of the addressed register, sampled on the edge at which `ack` rose.
- R4: A write (`rd_nwr`=0) takes effect exactly once per handshake, on the edge at which `ack` rises. Writable fields are: 0x0 bit0 insert enable, 0x3 bits[1:0] insert interrupt mask, 0x4 bits[1:0] insert overhead bits, 0x5 bit0 extract enable, 0x8 bits[1:0] extract interrupt mask, 0xA bits[4:0] high mark, 0xB bits[4:0] low mark. All other bits of these registers read 0.
- R5: Writes to the read-only addresses 0x1, 0x2, 0x6, 0x7 and 0x9, and to the unmapped addresses 0xC to 0xF, change no register. Unmapped addresses read 0.
- R6: Address 0x1 bit0 reads `ins_sync`, 0x6 bit0 reads `ext_sync`, and 0x9 bits[1:0] read `ext_oh`.
- R7: An event pulse on bit k of `ins_evt` or `ext_evt` sets bit k of 0x2 or 0x7 respectively, where bit1 flags FIFO corruption and bit0 flags structural corruption. The bit stays set until it is cleared by a read.
- R8: A read of 0x2 or 0x7 returns the flags and clears all of them on the edge at which `ack` rises.
- R9: An event arriving in the same cycle as the clearing read leaves its bit set; that read returns the value held before the edge.
- R10: `irq` is high exactly when some flag bit is set whose mask bit at 0x3 (insert) or 0x8 (extract) is also set.
- R11: `ins_en`, `ext_en`, `ins_oh`, `hi_mark` and `lo_mark` reflect the corresponding register fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Bus select |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| addr | input | 4 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not acknowledged |
| ack | output | 1 | Four-phase transfer acknowledge |
| irq | output | 1 | Interrupt request |
| ins_sync | input | 1 | Insert side sync status |
| ext_sync | input | 1 | Extract side sync status |
| ins_evt | input | 2 | Insert event pulses (bit1 FIFO, bit0 structure) |
| ext_evt | input | 2 | Extract event pulses (bit1 FIFO, bit0 structure) |
| ext_oh | input | 2 | Received overhead bits |
| ins_en | output | 1 | Insert enable |
| ext_en | output | 1 | Extract enable |
| ins_oh | output | 2 | Overhead bits to insert |
| hi_mark | output | 5 | FIFO high mark |
| lo_mark | output | 5 | FIFO low mark |

## Verification
The assertions assume a well-behaved master with three habits. It keeps `addr`, `rd_nwr` and `wdata` steady for as long as `sel` is high. It holds `sel` until it has seen `ack`. It waits for `ack` to fall before it selects the block again. The bench drives every transfer through one read task and one write task that follow exactly this order, and it changes inputs only on falling clock edges. Event pulses last one cycle. The only time they overlap a transfer is in the deliberate coincident-read case.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  localparam int ADR_INS_CTL = 0;
  localparam int ADR_INS_STS = 1;
  localparam int ADR_INS_IST = 2;
  localparam int ADR_INS_IEN = 3;
  localparam int ADR_INS_OHB = 4;
  localparam int ADR_EXT_CTL = 5;
  localparam int ADR_EXT_STS = 6;
  localparam int ADR_EXT_IST = 7;
  localparam int ADR_EXT_IEN = 8;
  localparam int ADR_EXT_OHB = 9;
  localparam int ADR_HI_MRK  = 10;
  localparam int ADR_LO_MRK  = 11;
  localparam int NUM_SIDES   = 2;
endpackage

// File: rtl/hsr_handshake.sv
module hsr_handshake (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  output logic ack,
  output logic acc
);
  logic ack_q;

  always_ff @(posedge clk) begin
    if (rst) ack_q <= 1'b0;
    else     ack_q <= sel;
  end

  assign ack = ack_q;
  // first cycle of a transfer: the edge ending it raises ack
  assign acc = sel & ~ack_q;
endmodule

// File: rtl/hsr_intr.sv
module hsr_intr #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         clr,
  input  logic [W-1:0] mask,
  output logic [W-1:0] flags,
  output logic         req
);
  logic [W-1:0] flg_q;

  always_ff @(posedge clk) begin
    if (rst) flg_q <= '0;
    else     flg_q <= (flg_q & ~{W{clr}}) | evt;
  end

  assign flags = flg_q;
  assign req   = |(flg_q & mask);
endmodule

// File: rtl/hs_reg_slave.sv
module hs_reg_slave
  import hsr_pkg::*;
#(
  parameter int DW     = 8,
  parameter int AW     = 4,
  parameter int IRQ_W  = 2,
  parameter int OH_W   = 2,
  parameter int MARK_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              rd_nwr,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              ack,
  output logic              irq,
  input  logic              ins_sync,
  input  logic              ext_sync,
  input  logic [IRQ_W-1:0]  ins_evt,
  input  logic [IRQ_W-1:0]  ext_evt,
  input  logic [OH_W-1:0]   ext_oh,
  output logic              ins_en,
  output logic              ext_en,
  output logic [OH_W-1:0]   ins_oh,
  output logic [MARK_W-1:0] hi_mark,
  output logic [MARK_W-1:0] lo_mark
);
  logic acc, wr_stb, rd_stb;
  logic ins_en_q, ext_en_q;
  logic [IRQ_W-1:0]  ins_ie_q, ext_ie_q;
  logic [OH_W-1:0]   ins_oh_q;
  logic [MARK_W-1:0] hi_q, lo_q;
  logic [DW-1:0]     rd_mux, rdata_q;

  logic [IRQ_W-1:0] side_evt [NUM_SIDES];
  logic [IRQ_W-1:0] side_ien [NUM_SIDES];
  logic [IRQ_W-1:0] side_flg [NUM_SIDES];
  logic             side_clr [NUM_SIDES];
  logic [NUM_SIDES-1:0] side_req;
  logic [IRQ_W-1:0] ins_ist, ext_ist;

  hsr_handshake u_hs (.clk(clk), .rst(rst), .sel(sel), .ack(ack), .acc(acc));

  assign wr_stb = acc & ~rd_nwr;
  assign rd_stb = acc & rd_nwr;

  assign side_evt[0] = ins_evt;
  assign side_evt[1] = ext_evt;
  assign side_ien[0] = ins_ie_q;
  assign side_ien[1] = ext_ie_q;
  assign side_clr[0] = rd_stb & (addr == AW'(ADR_INS_IST));
  assign side_clr[1] = rd_stb & (addr == AW'(ADR_EXT_IST));

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    hsr_intr #(.W(IRQ_W)) u_intr (
      .clk(clk), .rst(rst), .evt(side_evt[s]), .clr(side_clr[s]),
      .mask(side_ien[s]), .flags(side_flg[s]), .req(side_req[s])
    );
  end

  assign ins_ist = side_flg[0];
  assign ext_ist = side_flg[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ins_en_q <= 1'b0;
      ext_en_q <= 1'b0;
      ins_ie_q <= '0;
      ext_ie_q <= '0;
      ins_oh_q <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else if (wr_stb) begin
      case (addr)
        AW'(ADR_INS_CTL): ins_en_q <= wdata[0];
        AW'(ADR_INS_IEN): ins_ie_q <= wdata[IRQ_W-1:0];
        AW'(ADR_INS_OHB): ins_oh_q <= wdata[OH_W-1:0];
        AW'(ADR_EXT_CTL): ext_en_q <= wdata[0];
        AW'(ADR_EXT_IEN): ext_ie_q <= wdata[IRQ_W-1:0];
        AW'(ADR_HI_MRK):  hi_q     <= wdata[MARK_W-1:0];
        AW'(ADR_LO_MRK):  lo_q     <= wdata[MARK_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      AW'(ADR_INS_CTL): rd_mux = DW'(ins_en_q);
      AW'(ADR_INS_STS): rd_mux = DW'(ins_sync);
      AW'(ADR_INS_IST): rd_mux = DW'(ins_ist);
      AW'(ADR_INS_IEN): rd_mux = DW'(ins_ie_q);
      AW'(ADR_INS_OHB): rd_mux = DW'(ins_oh_q);
      AW'(ADR_EXT_CTL): rd_mux = DW'(ext_en_q);
      AW'(ADR_EXT_STS): rd_mux = DW'(ext_sync);
      AW'(ADR_EXT_IST): rd_mux = DW'(ext_ist);
      AW'(ADR_EXT_IEN): rd_mux = DW'(ext_ie_q);
      AW'(ADR_EXT_OHB): rd_mux = DW'(ext_oh);
      AW'(ADR_HI_MRK):  rd_mux = DW'(hi_q);
      AW'(ADR_LO_MRK):  rd_mux = DW'(lo_q);
      default:          rd_mux = '0;
    endcase
  end

  // captured once per read; dropped as soon as select goes away
  always_ff @(posedge clk) begin
    if (rst || !sel)  rdata_q <= '0;
    else if (rd_stb)  rdata_q <= rd_mux;
    else if (wr_stb)  rdata_q <= '0;
  end

  assign rdata   = rdata_q;
  assign irq     = |side_req;
  assign ins_en  = ins_en_q;
  assign ext_en  = ext_en_q;
  assign ins_oh  = ins_oh_q;
  assign hi_mark = hi_q;
  assign lo_mark = lo_q;
endmodule

// File: rtl/hsr_checker.sv
module hsr_checker #(
  parameter int DW = 8, parameter int AW = 4,
  parameter int IRQ_W = 2, parameter int MARK_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              sel,
  input logic              rd_nwr,
  input logic [AW-1:0]     addr,
  input logic              ack,
  input logic [DW-1:0]     rdata,
  input logic [MARK_W-1:0] hi_mark,
  input logic [IRQ_W-1:0]  ins_evt,
  input logic [IRQ_W-1:0]  ins_ist
);
  AST_ACK_RISE: assert property (@(posedge clk) disable iff (rst)
    sel |=> ack); // R2
  AST_ACK_FALL: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !ack); // R2
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !ack |-> (rdata == '0)); // R3
  AST_WRITE_ONCE: assert property (@(posedge clk) disable iff (rst)
    (sel && ack && !rd_nwr) |=> $stable(hi_mark)); // R4
  AST_EVT_STICKS: assert property (@(posedge clk) disable iff (rst)
    (|ins_evt) |=> ((ins_ist & $past(ins_evt)) == $past(ins_evt))); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (sel && !ack && rd_nwr && addr == AW'(2) && ins_evt == '0) |=> (ins_ist == '0)); // R8
endmodule

bind hs_reg_slave hsr_checker #(.DW(DW), .AW(AW), .IRQ_W(IRQ_W), .MARK_W(MARK_W)) u_chk (
  .clk(clk), .rst(rst), .sel(sel), .rd_nwr(rd_nwr), .addr(addr), .ack(ack),
  .rdata(rdata), .hi_mark(hi_mark), .ins_evt(ins_evt), .ins_ist(ins_ist)
);

// File: tb/test_hs_reg_slave.sv
`timescale 1ns/1ps
module test_hs_reg_slave;
  logic clk = 1'b0, rst = 1'b1;
  logic sel = 1'b0, rd_nwr = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic ack, irq, ins_en, ext_en;
  logic ins_sync = 1'b0, ext_sync = 1'b0;
  logic [1:0] ins_evt = '0, ext_evt = '0, ext_oh = '0, ins_oh;
  logic [4:0] hi_mark, lo_mark;
  int checks = 0, errors = 0;
  logic [7:0] model [16];
  logic [7:0] rv;

  always #10 clk = ~clk;

  hs_reg_slave i_hs_reg_slave (
    .clk(clk), .rst(rst), .sel(sel), .rd_nwr(rd_nwr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ack(ack), .irq(irq), .ins_sync(ins_sync), .ext_sync(ext_sync),
    .ins_evt(ins_evt), .ext_evt(ext_evt), .ext_oh(ext_oh), .ins_en(ins_en),
    .ext_en(ext_en), .ins_oh(ins_oh), .hi_mark(hi_mark), .lo_mark(lo_mark)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] wmask(input int a);
    case (a)
      0, 5: return 8'h01;
      3, 4, 8: return 8'h03;
      10, 11: return 8'h1f;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] expect_rd(input int a);
    case (a)
      1: return {7'd0, ins_sync};
      6: return {7'd0, ext_sync};
      9: return {6'd0, ext_oh};
      default: return model[a];
    endcase
  endfunction

  task automatic bus_write(input int a, input logic [7:0] d, input int hold = 0);
    @(negedge clk); sel = 1'b1; rd_nwr = 1'b0; addr = 4'(a); wdata = d;
    @(negedge clk);
    chk("R2 ack rise on write", ack, 1);
    chk("R3 rdata zero on write", rdata, 0);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R2 ack held", ack, 1);
    end
    sel = 1'b0;
    @(negedge clk);
    chk("R2 ack fall", ack, 0);
    model[a] = d & wmask(a);
  endtask

  task automatic bus_read(input int a, output logic [7:0] d);
    @(negedge clk); sel = 1'b1; rd_nwr = 1'b1; addr = 4'(a);
    @(negedge clk);
    chk("R2 ack rise on read", ack, 1);
    d = rdata;
    sel = 1'b0;
    @(negedge clk);
    chk("R2 ack fall after read", ack, 0);
    chk("R3 rdata zero after read", rdata, 0);
  endtask

  task automatic pulse(input logic [1:0] ie, input logic [1:0] ee);
    @(negedge clk); ins_evt = ie; ext_evt = ee;
    @(negedge clk); ins_evt = '0; ext_evt = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] pats [4];
    pats[0] = 8'hff; pats[1] = 8'ha5; pats[2] = 8'h5a; pats[3] = 8'h00;
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ack", ack, 0); chk("R1 rdata", rdata, 0); chk("R1 irq", irq, 0);
    chk("R1 outs", {ins_en, ext_en, ins_oh, hi_mark, lo_mark}, 0);
    for (int a = 0; a < 16; a++) begin
      bus_read(a, rv);
      chk("R1 reg zero", rv, 0);
    end

    // R4 R5 R6 sweep: every address written, every address read back
    for (int p = 0; p < 4; p++) begin
      ins_sync = p[0]; ext_sync = ~p[0]; ext_oh = 2'(p + 1);
      for (int a = 0; a < 16; a++) bus_write(a, pats[p] ^ 8'(a), a % 3);
      for (int a = 0; a < 16; a++) begin
        bus_read(a, rv);
        chk("R4 R5 R6 readback", rv, expect_rd(a));
      end
      // R11 output ports
      chk("R11 ins_en", ins_en, model[0][0]);
      chk("R11 ext_en", ext_en, model[5][0]);
      chk("R11 ins_oh", ins_oh, model[4][1:0]);
      chk("R11 hi_mark", hi_mark, model[10][4:0]);
      chk("R11 lo_mark", lo_mark, model[11][4:0]);
    end

    // R7 R10 interrupts
    bus_write(3, 8'h01); bus_write(8, 8'h02);
    pulse(2'b10, 2'b01);
    chk("R10 irq masked", irq, 0);
    bus_read(2, rv); chk("R7 R8 ins fifo flag", rv, 8'h02);
    bus_read(2, rv); chk("R8 ins cleared", rv, 8'h00);
    bus_read(7, rv); chk("R7 R8 ext struct flag", rv, 8'h01);
    pulse(2'b01, 2'b00);
    chk("R10 irq ins struct", irq, 1);
    pulse(2'b00, 2'b00);
    chk("R7 sticky irq", irq, 1);
    bus_read(2, rv); chk("R8 read returns", rv, 8'h01);
    chk("R8 R10 irq cleared", irq, 0);
    pulse(2'b00, 2'b10);
    chk("R10 irq ext fifo", irq, 1);
    bus_read(7, rv); chk("R8 ext read", rv, 8'h02);
    chk("R10 irq ext cleared", irq, 0);

    // R9 coincident event and clearing read
    pulse(2'b10, 2'b00);
    @(negedge clk); sel = 1'b1; rd_nwr = 1'b1; addr = 4'd2; ins_evt = 2'b01;
    @(negedge clk); ins_evt = '0;
    chk("R9 read returns prior", rdata, 8'h02);
    sel = 1'b0;
    @(negedge clk);
    chk("R9 irq kept", irq, 1);
    bus_read(2, rv); chk("R9 bit kept", rv, 8'h01);
    chk("R10 irq final", irq, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule